// File: doc/BRIEF.md
# Prescaled Event Interrupt Timer

This block is the interrupt timer of a game-cartridge memory controller. An 8-bit prescaler feeds an 8-bit counter. One of four single-cycle event strobes from the console side advances both of them: a CPU bus cycle, a rising edge of the picture processor's address line A12, a change of the picture processor's address, or a CPU write. The timer counts up or down. When the counter wraps it raises a level interrupt to the CPU, and the interrupt stays high until software acknowledges it.

Software reaches the timer through a small write-only port of eight byte offsets. Through this port it turns the timer on and off, sets the control byte, and loads the prescaler and the counter. A loaded value is first XORed with a separately written mask byte. A narrow-prescaler option makes only the low three prescaler bits step. A freeze option keeps the counter still while the prescaler runs, so the wrap test keeps using the held counter value.

Top module: `evt_irq_timer`

## Requirements
- R1: After reset the interrupt is low, the timer is off, and the control, mask, prescaler and counter are all zero.
- R2: Control bits [1:0] pick the event source: 0 = CPU cycle strobe, 1 = A12 rise strobe, 2 = address-change strobe, 3 = CPU write strobe. Strobes from the sources that are not picked have no effect.
- R3: In source 2, each address-change strobe applies two counting steps in the same clock.
- R4: Control bits [7:6] set the direction: 01 counts up and 10 counts down. With 00 or 11 an event changes nothing.
- R5: With control bit 2 set, only prescaler bits [2:0] step and bits [7:3] keep their value. With bit 2 clear, all 8 bits step.
- R6: Counting up, a step that brings the stepping prescaler bits to all zeros increments the counter. If the counter is then 0x00, the interrupt is raised.
- R7: Counting down, a step that brings the stepping prescaler bits to all ones decrements the counter. If the counter is then 0xFF, the interrupt is raised.
- R8: With control bit 3 set, the counter never changes, but each prescaler wrap still tests the held counter value against the R6/R7 value.
- R9: A write to offset 0 sets the on state from data bit 0; writing 0 there also zeroes the prescaler and drops the interrupt. Offset 2 turns the timer off, zeroes the prescaler and drops the interrupt. Offset 3 turns it on. Offset 1 writes the control byte.
- R10: Offsets 4 and 5 load the prescaler and the counter with the written byte XORed with the mask. Offset 6 writes the mask.
- R11: While the timer is off, no event changes the prescaler or the counter.
- R12: The interrupt is a level that stays high until an offset 2 write or an offset 0 write with bit 0 clear.
- R13: When a register write and an event fall in the same clock, the counting step uses the state from before the write, and the write then overrides the fields it targets. An interrupt raised by that step survives unless the write drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| ev_cpu_cyc | input | 1 | CPU bus cycle strobe |
| ev_a12_rise | input | 1 | A12 rising edge strobe |
| ev_addr_chg | input | 1 | Address change strobe |
| ev_cpu_wr | input | 1 | CPU write strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
A register write and a counting step can happen in the same clock. This is most natural in the CPU-write source, where every register access is also an event. The bench provokes this directly by pulsing the write strobe together with an event on a step that is known to wrap. It does so with an acknowledge write, a counter load and a control write. It then judges whether the interrupt was dropped, kept, or raised by the step that used the old control. Random traffic with many same-cycle collisions is compared, cycle by cycle, against a reference model that applies the step first and the write second.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    SRC_CPU_CYC  = 2'd0,
    SRC_A12      = 2'd1,
    SRC_ADDR_CHG = 2'd2,
    SRC_CPU_WR   = 2'd3
  } tmr_src_e;

  typedef enum logic [1:0] {
    DIR_IDLE_LO = 2'd0,
    DIR_UP      = 2'd1,
    DIR_DOWN    = 2'd2,
    DIR_IDLE_HI = 2'd3
  } tmr_dir_e;

  typedef enum logic [2:0] {
    OFS_EN   = 3'd0,
    OFS_CTL  = 3'd1,
    OFS_OFF  = 3'd2,
    OFS_ON   = 3'd3,
    OFS_PRE  = 3'd4,
    OFS_CNT  = 3'd5,
    OFS_MASK = 3'd6,
    OFS_NONE = 3'd7
  } tmr_ofs_e;

  // Stored control fields; data bits [5:4] carry no function.
  typedef struct packed {
    tmr_dir_e dir;     // data [7:6]
    logic     freeze;  // data [3]
    logic     narrow;  // data [2]
    tmr_src_e src;     // data [1:0]
  } tmr_ctl_t;

endpackage

// File: rtl/tmr_regfile.sv
`timescale 1ns/1ps
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output tmr_ctl_t      ctl,
  output logic          en,
  output logic          pre_ld,
  output logic          cnt_ld,
  output logic [DW-1:0] ld_val,
  output logic          clr
);

  tmr_ofs_e      ofs;
  tmr_ctl_t      ctl_q, ctl_d;
  logic          en_q, en_d, en_we;
  logic [DW-1:0] xm_q;
  logic          ctl_we, xm_we;

  assign ofs = tmr_ofs_e'(addr);

  // next-state decode
  always_comb begin
    ctl_we = wr && (ofs == OFS_CTL);
    xm_we  = wr && (ofs == OFS_MASK);
    en_we  = wr && ((ofs == OFS_EN) || (ofs == OFS_OFF) || (ofs == OFS_ON));
    ctl_d  = tmr_ctl_t'({wdata[7:6], wdata[3:0]});
    unique case (ofs)
      OFS_EN:  en_d = wdata[0];
      OFS_ON:  en_d = 1'b1;
      default: en_d = 1'b0;
    endcase
  end

  // R1: every register clears on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      en_q  <= 1'b0;
      xm_q  <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_d;
      if (en_we)  en_q  <= en_d;
      if (xm_we)  xm_q  <= wdata;
    end
  end

  assign ctl    = ctl_q;
  assign en     = en_q;
  assign pre_ld = wr && (ofs == OFS_PRE);
  assign cnt_ld = wr && (ofs == OFS_CNT);
  assign ld_val = wdata ^ xm_q;  // R10
  assign clr    = wr && (((ofs == OFS_EN) && !wdata[0]) || (ofs == OFS_OFF));

  p_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ofs == OFS_ON) |=> en_q);
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ofs == OFS_OFF) |=> !en_q);
  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && ofs == OFS_MASK) |=> (xm_q == $past(xm_q)));

endmodule

// File: rtl/tmr_evsel.sv
`timescale 1ns/1ps
module tmr_evsel
  import tmr_pkg::*;
#(
  parameter int unsigned CHG_STEPS = 2,
  localparam int unsigned SW = $clog2(CHG_STEPS + 1)
) (
  input  logic          en,
  input  tmr_src_e      src,
  input  tmr_dir_e      dir,
  input  logic          ev_cpu_cyc,
  input  logic          ev_a12_rise,
  input  logic          ev_addr_chg,
  input  logic          ev_cpu_wr,
  output logic [SW-1:0] nsteps
);

  logic active;

  // R4, R11: only an enabled timer with a counting direction takes steps
  assign active = en && ((dir == DIR_UP) || (dir == DIR_DOWN));

  // R2, R3: source selection and step count per event
  always_comb begin
    nsteps = '0;
    if (active) begin
      unique case (src)
        SRC_CPU_CYC:  nsteps = SW'(ev_cpu_cyc);
        SRC_A12:      nsteps = SW'(ev_a12_rise);
        SRC_ADDR_CHG: nsteps = ev_addr_chg ? SW'(CHG_STEPS) : '0;
        SRC_CPU_WR:   nsteps = SW'(ev_cpu_wr);
        default:      nsteps = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_step.sv
`timescale 1ns/1ps
module tmr_step #(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 3
) (
  input  logic [DW-1:0] pre_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          up,
  input  logic          narrow,
  input  logic          freeze,
  output logic [DW-1:0] pre_o,
  output logic [DW-1:0] cnt_o,
  output logic          fire
);

  localparam logic [DW-1:0] NMASK = DW'((1 << NW) - 1);

  logic [DW-1:0] mask, stepped, cnt_nx;
  logic          wrap;

  always_comb begin
    mask    = narrow ? NMASK : '1;                       // R5
    stepped = up ? pre_i + 1'b1 : pre_i - 1'b1;
    pre_o   = (pre_i & ~mask) | (stepped & mask);
    wrap    = up ? ((pre_o & mask) == '0)                // R6
                 : ((pre_o & mask) == mask);             // R7
    cnt_nx  = freeze ? cnt_i : (up ? cnt_i + 1'b1 : cnt_i - 1'b1);  // R8
    cnt_o   = wrap ? cnt_nx : cnt_i;
    fire    = wrap && (cnt_o == {DW{~up}});
  end

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int unsigned DW        = 8,
  parameter int unsigned NW        = 3,
  parameter int unsigned MAX_STEPS = 2,
  localparam int unsigned SW = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] nsteps,
  input  logic          up,
  input  logic          narrow,
  input  logic          freeze,
  input  logic          pre_ld,
  input  logic          cnt_ld,
  input  logic [DW-1:0] ld_val,
  input  logic          clr,
  output logic          irq
);

  logic [MAX_STEPS:0][DW-1:0] pre_c, cnt_c;
  logic [MAX_STEPS:0]         fire_c;
  logic [DW-1:0] pre_q, pre_d, cnt_q, cnt_d;
  logic          irq_q, irq_d;
  logic          pre_we, cnt_we, stepping;

  assign pre_c[0]  = pre_q;
  assign cnt_c[0]  = cnt_q;
  assign fire_c[0] = 1'b0;

  // R3: unrolled chain of step stages, stage g taken when g < nsteps
  for (genvar g = 0; g < MAX_STEPS; g++) begin : g_stage
    logic [DW-1:0] pre_s, cnt_s;
    logic          fire_s, take;
    tmr_step #(.DW(DW), .NW(NW)) u_step (
      .pre_i  (pre_c[g]),
      .cnt_i  (cnt_c[g]),
      .up     (up),
      .narrow (narrow),
      .freeze (freeze),
      .pre_o  (pre_s),
      .cnt_o  (cnt_s),
      .fire   (fire_s)
    );
    assign take       = (nsteps > SW'(g));
    assign pre_c[g+1] = take ? pre_s : pre_c[g];
    assign cnt_c[g+1] = take ? cnt_s : cnt_c[g];
    assign fire_c[g+1] = fire_c[g] | (take & fire_s);
  end

  // R13: step result first, register write overrides afterwards
  always_comb begin
    stepping = (nsteps != '0);
    pre_we   = stepping || pre_ld || clr;
    cnt_we   = stepping || cnt_ld;
    pre_d    = clr ? '0 : (pre_ld ? ld_val : pre_c[MAX_STEPS]);
    cnt_d    = cnt_ld ? ld_val : cnt_c[MAX_STEPS];
    irq_d    = (irq_q | fire_c[MAX_STEPS]) & ~clr;   // R12
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (pre_we) pre_q <= pre_d;
      if (cnt_we) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_q);
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && nsteps == '0) |=> !irq_q);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nsteps == '0 && !pre_ld && !cnt_ld && !clr) |=> ($stable(pre_q) && $stable(cnt_q)));
  p_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && !pre_ld && !clr) |=> (pre_q[DW-1:NW] == $past(pre_q[DW-1:NW])));
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_ld) |=> $stable(cnt_q));
  p_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nsteps == SW'(MAX_STEPS) && up && !narrow && !pre_ld && !clr)
      |=> (pre_q == $past(pre_q) + DW'(MAX_STEPS)));

endmodule

// File: rtl/evt_irq_timer.sv
`timescale 1ns/1ps
module evt_irq_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned NW        = 3,
  parameter int unsigned CHG_STEPS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          ev_cpu_cyc,
  input  logic          ev_a12_rise,
  input  logic          ev_addr_chg,
  input  logic          ev_cpu_wr,
  output logic          irq_o
);

  localparam int unsigned SW = $clog2(CHG_STEPS + 1);

  logic [1:0]    rs_q;
  logic          rst_ni;
  tmr_ctl_t      ctl;
  logic          en, pre_ld, cnt_ld, clr;
  logic [DW-1:0] ld_val;
  logic [SW-1:0] nsteps;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  tmr_regfile #(.DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_ni),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ctl    (ctl),
    .en     (en),
    .pre_ld (pre_ld),
    .cnt_ld (cnt_ld),
    .ld_val (ld_val),
    .clr    (clr)
  );

  tmr_evsel #(.CHG_STEPS(CHG_STEPS)) u_sel (
    .en          (en),
    .src         (ctl.src),
    .dir         (ctl.dir),
    .ev_cpu_cyc  (ev_cpu_cyc),
    .ev_a12_rise (ev_a12_rise),
    .ev_addr_chg (ev_addr_chg),
    .ev_cpu_wr   (ev_cpu_wr),
    .nsteps      (nsteps)
  );

  tmr_core #(.DW(DW), .NW(NW), .MAX_STEPS(CHG_STEPS)) u_core (
    .clk    (clk),
    .rst_n  (rst_ni),
    .nsteps (nsteps),
    .up     (ctl.dir == DIR_UP),
    .narrow (ctl.narrow),
    .freeze (ctl.freeze),
    .pre_ld (pre_ld),
    .cnt_ld (cnt_ld),
    .ld_val (ld_val),
    .clr    (clr),
    .irq    (irq_o)
  );

  p_src_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl.src != SRC_ADDR_CHG) |-> (nsteps <= SW'(1)));

endmodule

// File: tb/sim_evt_irq_timer.sv
`timescale 1ns/1ps
module sim_evt_irq_timer;

  localparam logic [3:0] E_CYC = 4'b0001, E_A12 = 4'b0010, E_CHG = 4'b0100, E_WR = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       ev_cpu_cyc = 1'b0, ev_a12_rise = 1'b0, ev_addr_chg = 1'b0, ev_cpu_wr = 1'b0;
  logic       irq_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  // reference state
  logic       m_en = 1'b0, m_irq = 1'b0;
  logic [7:0] m_ctl = '0, m_x = '0, m_pre = '0, m_cnt = '0;

  always #2 clk = ~clk;

  evt_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ev_cpu_cyc(ev_cpu_cyc), .ev_a12_rise(ev_a12_rise), .ev_addr_chg(ev_addr_chg),
    .ev_cpu_wr(ev_cpu_wr), .irq_o(irq_o)
  );

  task automatic chk(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b at %0t", t, act, exp, $time);
    end
  endtask

  function automatic void m_one(input logic [7:0] ctl, inout logic [7:0] p,
                                inout logic [7:0] c, inout logic f);
    logic [7:0] msk;
    msk = ctl[2] ? 8'h07 : 8'hFF;
    if (ctl[7:6] == 2'b01) begin
      p = (p & ~msk) | ((p + 8'd1) & msk);
      if ((p & msk) == 8'h00) begin
        if (!ctl[3]) c = c + 8'd1;
        if (c == 8'h00) f = 1'b1;
      end
    end else if (ctl[7:6] == 2'b10) begin
      p = (p & ~msk) | ((p - 8'd1) & msk);
      if ((p & msk) == msk) begin
        if (!ctl[3]) c = c - 8'd1;
        if (c == 8'hFF) f = 1'b1;
      end
    end
  endfunction

  task automatic m_clock(input logic w, input logic [2:0] a, input logic [7:0] d, input logic [3:0] e);
    int   n;
    logic f;
    n = 0;
    f = 1'b0;
    if (m_en) begin
      case (m_ctl[1:0])
        2'd0: n = int'(e[0]);
        2'd1: n = int'(e[1]);
        2'd2: n = e[2] ? 2 : 0;
        default: n = int'(e[3]);
      endcase
    end
    for (int i = 0; i < n; i++) m_one(m_ctl, m_pre, m_cnt, f);
    if (f) m_irq = 1'b1;
    if (w) begin
      case (a)
        3'd0: begin m_en = d[0]; if (!d[0]) begin m_pre = '0; m_irq = 1'b0; end end
        3'd1: m_ctl = d;
        3'd2: begin m_en = 1'b0; m_pre = '0; m_irq = 1'b0; end
        3'd3: m_en = 1'b1;
        3'd4: m_pre = d ^ m_x;
        3'd5: m_cnt = d ^ m_x;
        3'd6: m_x = d;
        default: ;
      endcase
    end
  endtask

  // called at a falling edge: drive, advance model, compare at next falling edge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic [3:0] e);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    ev_cpu_cyc = e[0]; ev_a12_rise = e[1]; ev_addr_chg = e[2]; ev_cpu_wr = e[3];
    m_clock(w, a, d, e);
    @(posedge clk);
    @(negedge clk);
    chk(irq_o, m_irq, tag);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 4'h0);
  endtask

  task automatic ev(input logic [3:0] e, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, e);
  endtask

  task automatic restart(input logic [7:0] ctl, input logic [7:0] pre, input logic [7:0] cnt);
    wreg(3'd2, 8'h00);
    wreg(3'd3, 8'h00);
    wreg(3'd1, ctl);
    wreg(3'd4, pre ^ m_x);
    wreg(3'd5, cnt ^ m_x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_o, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq_o, 1'b0, "R1 after reset");

    // R11: off after reset, all strobes ignored
    tag = "R11"; ev(4'hF, 20); chk(irq_o, 1'b0, "R11 off after reset");

    // R4: enabled, loaded near wrap, idle directions
    tag = "R4";
    wreg(3'd3, 8'h00); wreg(3'd4, 8'hFE); wreg(3'd5, 8'hFF);
    ev(4'hF, 300); chk(irq_o, 1'b0, "R4 dir 00 no count");
    wreg(3'd1, 8'hC0);
    ev(4'hF, 300); chk(irq_o, 1'b0, "R4 dir 11 no count");

    // R6: up wrap
    tag = "R6"; restart(8'h40, 8'hFE, 8'hFF);
    ev(E_CYC, 1); chk(irq_o, 1'b0, "R6 first step no wrap");
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R6 wrap to 00");
    wreg(3'd2, 8'h00); chk(irq_o, 1'b0, "R9 offset 2 acknowledges");

    // R7: down wrap
    tag = "R7"; restart(8'h80, 8'h01, 8'h00);
    ev(E_CYC, 1); chk(irq_o, 1'b0, "R7 first step no wrap");
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R7 wrap to FF");

    // R12: level held, cleared only by the right writes
    tag = "R12"; ev(E_CYC, 10); chk(irq_o, 1'b1, "R12 held under events");
    wreg(3'd0, 8'h01); chk(irq_o, 1'b1, "R12 offset 0 bit0=1 keeps irq");
    wreg(3'd6, 8'h00); wreg(3'd1, 8'h80); chk(irq_o, 1'b1, "R12 other writes keep irq");
    wreg(3'd0, 8'h00); chk(irq_o, 1'b0, "R9 offset 0 bit0=0 drops irq");

    // R11 then R9 enable: prescaler was zeroed by offset 0
    tag = "R11"; wreg(3'd5, 8'h00);
    ev(E_CYC, 600); chk(irq_o, 1'b0, "R11 no counting while off");
    wreg(3'd3, 8'h00);
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R9 offset 3 enables, zeroed prescaler wraps down");

    // R5: narrow prescaler, upper bits held and then reused in wide mode
    tag = "R5"; restart(8'h44, 8'hF6, 8'hFE);
    ev(E_CYC, 2); chk(irq_o, 1'b0, "R5 narrow wrap, counter to FF");
    wreg(3'd1, 8'h40);
    ev(E_CYC, 15); chk(irq_o, 1'b0, "R5 upper bits kept F0");
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R5 wide wrap after 16 steps");

    // R8: freeze
    tag = "R8"; restart(8'h48, 8'hFF, 8'h00);
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R8 held counter 00 fires");
    restart(8'h48, 8'h00, 8'h05);
    ev(E_CYC, 600); chk(irq_o, 1'b0, "R8 frozen counter never fires");

    // R2/R3: source selection
    tag = "R2"; restart(8'h42, 8'hFE, 8'hFF);
    ev(E_CYC | E_A12 | E_WR, 10); chk(irq_o, 1'b0, "R2 src 2 ignores others");
    tag = "R3"; ev(E_CHG, 1); chk(irq_o, 1'b1, "R3 one change gives two steps");
    tag = "R2"; restart(8'h41, 8'hFE, 8'hFF);
    ev(E_CYC | E_CHG | E_WR, 10); chk(irq_o, 1'b0, "R2 src 1 ignores others");
    ev(E_A12, 1); chk(irq_o, 1'b0, "R2 one A12 step");
    ev(E_A12, 1); chk(irq_o, 1'b1, "R2 A12 wrap");
    restart(8'h43, 8'hFE, 8'hFF);
    ev(E_CYC | E_A12 | E_CHG, 10); chk(irq_o, 1'b0, "R2 src 3 ignores others");
    ev(E_WR, 2); chk(irq_o, 1'b1, "R2 write strobe wrap");

    // R10: xor-masked loads
    tag = "R10"; wreg(3'd6, 8'h5A);
    restart(8'h40, 8'hFE, 8'hFF);
    ev(E_CYC, 1); chk(irq_o, 1'b0, "R10 masked prescaler load");
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R10 masked counter load");
    wreg(3'd6, 8'h00);

    // R13: same-cycle collisions
    tag = "R13"; restart(8'h43, 8'hFF, 8'hFF);
    cyc(1'b1, 3'd2, 8'h00, E_WR); chk(irq_o, 1'b0, "R13 ack beats wrap");
    restart(8'h43, 8'hFF, 8'hFF);
    cyc(1'b1, 3'd5, 8'h10, E_WR); chk(irq_o, 1'b1, "R13 wrap survives counter load");
    restart(8'h40, 8'hFF, 8'hFF);
    cyc(1'b1, 3'd1, 8'h00, E_CYC); chk(irq_o, 1'b1, "R13 step uses old control");
    ev(E_CYC, 1); chk(irq_o, 1'b1, "R13 irq held after control write");

    // random traffic against the model
    void'($urandom(32'd7351));
    restart(8'h40, 8'h00, 8'h00);
    for (int k = 0; k < 6000; k++) begin
      logic       w;
      logic [2:0] a;
      logic [7:0] d;
      logic [3:0] e;
      w = ($urandom_range(0, 3) == 0);
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd1 && $urandom_range(0, 7) != 0) d[7:6] = $urandom_range(0, 1) ? 2'b01 : 2'b10;
      if ((a == 3'd4 || a == 3'd5) && $urandom_range(0, 1) != 0)
        d = m_x ^ ($urandom_range(0, 1) ? 8'hFF : 8'h00) ^ 8'($urandom_range(0, 2));
      if ((a == 3'd2 || (a == 3'd0 && !d[0])) && $urandom_range(0, 3) != 0) a = 3'd3;
      e = 4'($urandom);
      cyc(w, a, d, e);
    end
    cyc(1'b0, 3'd0, 8'h00, 4'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL %s watchdog expired actual=hung expected=done", tag);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule